// File: doc/BRIEF.md
# Stack Call and Return Sequencer

This block moves 16-bit words between an 8-bit processor core and its stack through a byte-wide memory port. The core issues one command at a time: push, pop, call, conditional call, return, conditional return or restart. The command comes with a data word, a return address, the restart opcode and the outcome of the branch condition. The sequencer then spends two cycles driving memory address, write data and write enable. It moves the 16-bit stack pointer one byte per cycle. When it finishes, it reports the popped word or the new program counter.

A push or a call stores the high byte below the current stack pointer and then the low byte below that. A pop or a return reads in the opposite order. With the word-select input set, a push packs the accumulator and five flags into a single word. The popped word is always available unpacked as an accumulator byte and five flags. A conditional command whose condition is false completes at once and makes no memory access. A dedicated load path sets the stack pointer between commands.

Top module: `stack_seq`

## Requirements
- R1: A push (cmdOp 0) writes the high byte of its word at SP-1 in the first busy cycle and the low byte at SP-2 in the second, leaving SP decreased by 2. Calls (cmdOp 2, 3) and restart (cmdOp 6) push the return address in the same order.
- R2: A pop (cmdOp 1) reads the low byte at SP and then the high byte at SP+1, presents the word on popWord and leaves SP increased by 2.
- R3: A call (cmdOp 2) completes with pcLoad high and pcOut equal to cmdWord, the target address.
- R4: A restart (cmdOp 6) completes with pcLoad high and pcOut equal to vecOpcode AND 0x38, zero-extended.
- R5: A conditional call (cmdOp 3) or conditional return (cmdOp 5) with condTaken low makes no memory access, leaves SP unchanged, raises done in the next cycle and keeps pcLoad low. With condTaken high it behaves as cmdOp 2 or cmdOp 4.
- R6: A return (cmdOp 4) pops a word as in R2 and completes with pcLoad high and pcOut equal to that word. Nested calls and returns restore PC and SP in last-in first-out order.
- R7: A push with pswSel high stores accIn as the high byte. The low byte holds flagsIn bits {4,3,2,1,0} (sign, zero, aux carry, parity, carry) at bits 7, 6, 4, 2 and 0, with bit 1 forced to 1 and bits 5 and 3 forced to 0.
- R8: accOut is the high byte of popWord. flagsOut is {bit7, bit6, bit4, bit2, bit0} of popWord. Bits 5, 3 and 1 have no effect.
- R9: done is high for exactly one cycle, three cycles after a stack-accessing command is accepted. pcLoad is high only together with done. A command or an SP load presented while busy is ignored, and cmdOp 7 is ignored.
- R10: SP wraps modulo 65536 both when decremented below 0x0000 and when incremented past 0xFFFF.
- R11: After reset SP, popWord and pcOut are 0, and busy, done, pcLoad and memWe are low.
- R12: spWrEn loads spWrVal into SP on the next edge when the block is idle and cmdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 3 | Command code (0 push, 1 pop, 2 call, 3 cond call, 4 return, 5 cond return, 6 restart, 7 none) |
| condTaken | input | 1 | Condition outcome for conditional commands |
| cmdWord | input | 16 | Push data or call target |
| retAddr | input | 16 | Return address stored by call and restart |
| vecOpcode | input | 8 | Restart opcode supplying the vector bits |
| pswSel | input | 1 | Push the packed accumulator and flags word |
| accIn | input | 8 | Accumulator for a packed push |
| flagsIn | input | 5 | Sign, zero, aux carry, parity, carry |
| spWrEn | input | 1 | Stack pointer load strobe |
| spWrVal | input | 16 | Stack pointer load value |
| memRdata | input | 8 | Memory read data for memAddr, same cycle |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| sp | output | 16 | Current stack pointer |
| popWord | output | 16 | Last popped word |
| accOut | output | 8 | Accumulator unpacked from popWord |
| flagsOut | output | 5 | Flags unpacked from popWord |
| pcOut | output | 16 | New program counter, valid with pcLoad |
| pcLoad | output | 1 | Program counter load strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completion pulse |

## Verification
The words pushed and popped use distinct high and low bytes (0x1234, 0xABCD, 0xBEEF), so a swapped byte order or a wrong address step shows up as a mismatched memory byte or an off-by-one SP. A three-level chain of call, call and restart, followed by three returns, shows whether the stack unwinds last-in first-out and whether pcOut takes the target, the vector or the popped word. Conditional commands run with the condition both false and true, and the false case must show no write and a one-cycle completion. Flag words with alternating bits and words with only the ignored bits set test the packed layout. A stack pointer at 0x0001 forces wrap in both directions.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam logic [7:0] VEC_MASK = 8'h38;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_CALLC = 3'd3,
    OP_RET   = 3'd4,
    OP_RETC  = 3'd5,
    OP_RST   = 3'd6,
    OP_NONE  = 3'd7
  } seqOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;     // capture command operands
    logic selRet;    // push word is the return address
    logic selVec;    // target comes from the restart opcode
    logic pushStep;  // write a byte and decrement SP
    logic hiPhase;   // first byte of the pair
    logic popStep;   // read a byte and increment SP
    logic capLo;     // hold the low byte read
    logic finish;    // last byte cycle
    logic pcFromPop; // new PC is the popped word
    logic spLoad;    // direct SP load
  } seqCtl_t;
endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       condTaken,
  input  logic       spWrEn,
  output seqCtl_t    ctl,
  output logic       busy,
  output logic       done,
  output logic       pcLoad
);
  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} seqState_e;

  seqState_e stQ;
  seqOp_e    opQ;
  seqOp_e    opIn;
  logic      doneQ, pcLoadQ;
  logic      accept, skip, condOp, pushOpQ, popOpQ, active;

  assign opIn    = seqOp_e'(cmdOp);
  assign accept  = cmdValid && (stQ == S_IDLE) && (opIn != OP_NONE);
  assign condOp  = (opIn == OP_CALLC) || (opIn == OP_RETC);
  assign skip    = accept && condOp && !condTaken;
  assign pushOpQ = (opQ == OP_PUSH) || (opQ == OP_CALL) || (opQ == OP_CALLC) || (opQ == OP_RST);
  assign popOpQ  = (opQ == OP_POP) || (opQ == OP_RET) || (opQ == OP_RETC);
  assign active  = (stQ != S_IDLE);

  always_comb begin
    ctl           = '0;
    ctl.latch     = accept && !skip;
    ctl.selRet    = (opIn == OP_CALL) || (opIn == OP_CALLC) || (opIn == OP_RST);
    ctl.selVec    = (opIn == OP_RST);
    ctl.pushStep  = active && pushOpQ;
    ctl.hiPhase   = (stQ == S_FIRST);
    ctl.popStep   = active && popOpQ;
    ctl.capLo     = popOpQ && (stQ == S_FIRST);
    ctl.finish    = (stQ == S_SECOND);
    ctl.pcFromPop = (opQ == OP_RET) || (opQ == OP_RETC);
    ctl.spLoad    = spWrEn && (stQ == S_IDLE) && !cmdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ     <= S_IDLE;
      opQ     <= OP_NONE;
      doneQ   <= 1'b0;
      pcLoadQ <= 1'b0;
    end else begin
      doneQ   <= skip || (stQ == S_SECOND);
      pcLoadQ <= (stQ == S_SECOND) && (opQ != OP_PUSH) && (opQ != OP_POP);
      unique case (stQ)
        S_IDLE: if (ctl.latch) begin
          stQ <= S_FIRST;
          opQ <= opIn;
        end
        S_FIRST:  stQ <= S_SECOND;
        S_SECOND: stQ <= S_IDLE;
        default:  stQ <= S_IDLE;
      endcase
    end
  end

  assign busy   = active;
  assign done   = doneQ;
  assign pcLoad = pcLoadQ;
endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtl_t       ctl,
  input  logic [AW-1:0] cmdWord,
  input  logic [AW-1:0] retAddr,
  input  logic [AW/2-1:0] vecOpcode,
  input  logic          pswSel,
  input  logic [AW/2-1:0] accIn,
  input  logic [4:0]    flagsIn,
  input  logic [AW-1:0] spWrVal,
  input  logic [AW/2-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [AW/2-1:0] memWdata,
  output logic          memWe,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] popWord,
  output logic [AW/2-1:0] accOut,
  output logic [4:0]    flagsOut,
  output logic [AW-1:0] pcOut
);
  localparam int BW = AW / 2;

  logic [AW-1:0] spQ, pushWordQ, targetQ, popWordQ, pcQ;
  logic [BW-1:0] loQ, flagByte;
  logic [AW-1:0] packedPsw, nextPush, vecAddr, readWord;

  // fixed flag layout, bit 1 constant one
  always_comb begin
    flagByte    = '0;
    flagByte[7] = flagsIn[4];
    flagByte[6] = flagsIn[3];
    flagByte[4] = flagsIn[2];
    flagByte[2] = flagsIn[1];
    flagByte[1] = 1'b1;
    flagByte[0] = flagsIn[0];
  end

  always_comb begin
    vecAddr      = '0;
    vecAddr[7:0] = vecOpcode[7:0] & VEC_MASK;
  end

  assign packedPsw = {accIn, flagByte};
  assign nextPush  = ctl.selRet ? retAddr : (pswSel ? packedPsw : cmdWord);
  assign readWord  = {memRdata, loQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ       <= '0;
      pushWordQ <= '0;
      targetQ   <= '0;
      loQ       <= '0;
      popWordQ  <= '0;
      pcQ       <= '0;
    end else begin
      if (ctl.latch) begin
        pushWordQ <= nextPush;
        targetQ   <= ctl.selVec ? vecAddr : cmdWord;
      end
      if (ctl.spLoad)        spQ <= spWrVal;
      else if (ctl.pushStep) spQ <= spQ - 1'b1;
      else if (ctl.popStep)  spQ <= spQ + 1'b1;
      if (ctl.capLo) loQ <= memRdata;
      if (ctl.finish && ctl.popStep) popWordQ <= readWord;
      if (ctl.finish) pcQ <= ctl.pcFromPop ? readWord : targetQ;
    end
  end

  assign memAddr  = ctl.pushStep ? (spQ - 1'b1) : spQ;
  assign memWdata = ctl.hiPhase ? pushWordQ[AW-1:BW] : pushWordQ[BW-1:0];
  assign memWe    = ctl.pushStep;
  assign sp       = spQ;
  assign popWord  = popWordQ;
  assign accOut   = popWordQ[AW-1:BW];
  assign flagsOut = {popWordQ[7], popWordQ[6], popWordQ[4], popWordQ[2], popWordQ[0]};
  assign pcOut    = pcQ;
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic            condTaken,
  input  logic [AW-1:0]   cmdWord,
  input  logic [AW-1:0]   retAddr,
  input  logic [AW/2-1:0] vecOpcode,
  input  logic            pswSel,
  input  logic [AW/2-1:0] accIn,
  input  logic [4:0]      flagsIn,
  input  logic            spWrEn,
  input  logic [AW-1:0]   spWrVal,
  input  logic [AW/2-1:0] memRdata,
  output logic [AW-1:0]   memAddr,
  output logic [AW/2-1:0] memWdata,
  output logic            memWe,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   popWord,
  output logic [AW/2-1:0] accOut,
  output logic [4:0]      flagsOut,
  output logic [AW-1:0]   pcOut,
  output logic            pcLoad,
  output logic            busy,
  output logic            done
);
  seqCtl_t ctl;

  stack_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .condTaken(condTaken), .spWrEn(spWrEn), .ctl(ctl),
    .busy(busy), .done(done), .pcLoad(pcLoad)
  );

  stack_seq_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdWord(cmdWord), .retAddr(retAddr),
    .vecOpcode(vecOpcode), .pswSel(pswSel), .accIn(accIn), .flagsIn(flagsIn),
    .spWrVal(spWrVal), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .sp(sp), .popWord(popWord),
    .accOut(accOut), .flagsOut(flagsOut), .pcOut(pcOut)
  );
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [2:0]    cmdOp,
  input logic          condTaken,
  input logic          busy,
  input logic          done,
  input logic          pcLoad,
  input logic          memWe,
  input logic [AW-1:0] sp
);
  p_push_dec_r1: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (sp == $past(sp) - 1'b1));

  p_pair_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |=> memWe);

  p_write_end_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |=> !memWe);

  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && ((cmdOp == 3'd3) || (cmdOp == 3'd5)) && !condTaken)
      |=> (done && !memWe && !pcLoad && $stable(sp)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_pcload_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> done);
endmodule

bind stack_seq stack_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .condTaken(condTaken), .busy(busy), .done(done), .pcLoad(pcLoad),
  .memWe(memWe), .sp(sp)
);

// File: tb/stack_seq_tb.sv
module stack_seq_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid, condTaken, pswSel, spWrEn;
  logic [2:0]  cmdOp;
  logic [15:0] cmdWord, retAddr, spWrVal;
  logic [7:0]  vecOpcode, accIn;
  logic [4:0]  flagsIn;
  logic [7:0]  memRdata;
  logic [15:0] memAddr, sp, popWord, pcOut;
  logic [7:0]  memWdata, accOut;
  logic [4:0]  flagsOut;
  logic        memWe, pcLoad, busy, done;

  logic [7:0]  mem [0:255];
  logic        tbWe;
  logic [7:0]  tbAddr, tbData;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stack_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .condTaken(condTaken), .cmdWord(cmdWord), .retAddr(retAddr),
    .vecOpcode(vecOpcode), .pswSel(pswSel), .accIn(accIn), .flagsIn(flagsIn),
    .spWrEn(spWrEn), .spWrVal(spWrVal), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .sp(sp),
    .popWord(popWord), .accOut(accOut), .flagsOut(flagsOut), .pcOut(pcOut),
    .pcLoad(pcLoad), .busy(busy), .done(done)
  );

  // behavioural memory, low address byte only
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
    end else if (tbWe) begin
      mem[tbAddr] <= tbData;
    end
  end
  assign memRdata = mem[memAddr[7:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [15:0] word, input logic [15:0] ret,
                        input logic [7:0] opc, input logic psw, input logic cnd,
                        output int lat, output logic pl);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdWord = word; retAddr = ret;
    vecOpcode = opc; pswSel = psw; condTaken = cnd;
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    pl = pcLoad;
  endtask

  task automatic loadSp(input logic [15:0] v);
    @(negedge clk);
    spWrEn = 1'b1; spWrVal = v;
    @(negedge clk);
    spWrEn = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic testReset;
    chk("R11 sp", sp, 16'h0000);
    chk("R11 busy", busy, 1'b0);
    chk("R11 done", done, 1'b0);
    chk("R11 memWe", memWe, 1'b0);
    chk("R11 pcLoad", pcLoad, 1'b0);
    chk("R11 popWord", popWord, 16'h0000);
    chk("R11 pcOut", pcOut, 16'h0000);
  endtask

  task automatic testPushPop;
    int lat; logic pl;
    loadSp(16'h0040);
    chk("R12 sp load", sp, 16'h0040);
    runCmd(3'd0, 16'h1234, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R9 push latency", lat, 3);
    chk("R9 push no pcLoad", pl, 1'b0);
    chk("R1 sp after push", sp, 16'h003E);
    chk("R1 high byte at sp-1", mem[8'h3F], 8'h12);
    chk("R1 low byte at sp-2", mem[8'h3E], 8'h34);
    poke(8'h50, 8'hCD);
    poke(8'h51, 8'hAB);
    loadSp(16'h0050);
    runCmd(3'd1, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R2 pop word", popWord, 16'hABCD);
    chk("R2 sp after pop", sp, 16'h0052);
    chk("R9 pop latency", lat, 3);
  endtask

  task automatic testNested;
    int lat; logic pl;
    loadSp(16'h0040);
    runCmd(3'd2, 16'h2000, 16'h0103, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R3 call pcLoad", pl, 1'b1);
    chk("R3 call target", pcOut, 16'h2000);
    chk("R3 ret addr hi", mem[8'h3F], 8'h01);
    chk("R3 ret addr lo", mem[8'h3E], 8'h03);
    runCmd(3'd2, 16'h3000, 16'h2003, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R3 nested sp", sp, 16'h003C);
    runCmd(3'd6, 16'hFFFF, 16'h3001, 8'hEF, 1'b0, 1'b0, lat, pl);
    chk("R4 restart pcLoad", pl, 1'b1);
    chk("R4 restart vector", pcOut, 16'h0028);
    chk("R4 restart sp", sp, 16'h003A);
    chk("R4 restart ret lo", mem[8'h3A], 8'h01);
    runCmd(3'd4, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R6 return 1 pc", pcOut, 16'h3001);
    chk("R6 return 1 pcLoad", pl, 1'b1);
    runCmd(3'd4, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R6 return 2 pc", pcOut, 16'h2003);
    runCmd(3'd4, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R6 return 3 pc", pcOut, 16'h0103);
    chk("R6 sp restored", sp, 16'h0040);
  endtask

  task automatic testCond;
    int lat; logic pl;
    runCmd(3'd3, 16'h4444, 16'h5555, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R5 false call latency", lat, 1);
    chk("R5 false call no pcLoad", pl, 1'b0);
    chk("R5 false call sp", sp, 16'h0040);
    chk("R5 false call mem hi", mem[8'h3F], 8'h01);
    chk("R5 false call mem lo", mem[8'h3E], 8'h03);
    runCmd(3'd3, 16'h4444, 16'h5555, 8'h0, 1'b0, 1'b1, lat, pl);
    chk("R5 true call pc", pcOut, 16'h4444);
    chk("R5 true call sp", sp, 16'h003E);
    chk("R5 true call mem", mem[8'h3F], 8'h55);
    runCmd(3'd5, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R5 false return latency", lat, 1);
    chk("R5 false return sp", sp, 16'h003E);
    chk("R5 false return no pcLoad", pl, 1'b0);
    runCmd(3'd5, 16'h0, 16'h0, 8'h0, 1'b0, 1'b1, lat, pl);
    chk("R5 true return pc", pcOut, 16'h5555);
    chk("R5 true return sp", sp, 16'h0040);
  endtask

  task automatic testPsw;
    int lat; logic pl;
    loadSp(16'h0080);
    accIn = 8'hA5; flagsIn = 5'b10101;
    runCmd(3'd0, 16'h0000, 16'h0, 8'h0, 1'b1, 1'b0, lat, pl);
    chk("R7 acc byte", mem[8'h7F], 8'hA5);
    chk("R7 flag byte 10101", mem[8'h7E], 8'h93);
    accIn = 8'h3C; flagsIn = 5'b00000;
    runCmd(3'd0, 16'h0000, 16'h0, 8'h0, 1'b1, 1'b0, lat, pl);
    chk("R7 flag byte zero", mem[8'h7C], 8'h02);
    chk("R7 acc byte 2", mem[8'h7D], 8'h3C);
    poke(8'h90, 8'h2A);
    poke(8'h91, 8'h77);
    poke(8'h92, 8'hD5);
    poke(8'h93, 8'h81);
    loadSp(16'h0090);
    runCmd(3'd1, 16'h0, 16'h0, 8'h0, 1'b1, 1'b0, lat, pl);
    chk("R8 ignored bits flags", flagsOut, 5'b00000);
    chk("R8 acc", accOut, 8'h77);
    runCmd(3'd1, 16'h0, 16'h0, 8'h0, 1'b1, 1'b0, lat, pl);
    chk("R8 all flags", flagsOut, 5'b11111);
    chk("R8 acc 2", accOut, 8'h81);
  endtask

  task automatic testWrap;
    int lat; logic pl;
    loadSp(16'h0001);
    runCmd(3'd0, 16'hBEEF, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R10 sp wrap down", sp, 16'hFFFF);
    chk("R10 hi at 0000", mem[8'h00], 8'hBE);
    chk("R10 lo at FFFF", mem[8'hFF], 8'hEF);
    runCmd(3'd1, 16'h0, 16'h0, 8'h0, 1'b0, 1'b0, lat, pl);
    chk("R10 pop across wrap", popWord, 16'hBEEF);
    chk("R10 sp wrap up", sp, 16'h0001);
  endtask

  task automatic testBusyIgnore;
    loadSp(16'h0060);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd0; cmdWord = 16'h7777; pswSel = 1'b0;
    @(negedge clk);
    cmdOp = 3'd1; spWrEn = 1'b1; spWrVal = 16'h0099;
    chk("R9 busy during command", busy, 1'b1);
    @(negedge clk);
    cmdValid = 1'b0; spWrEn = 1'b0;
    @(negedge clk);
    chk("R9 done after busy stimulus", done, 1'b1);
    chk("R9 busy stimulus ignored sp", sp, 16'h005E);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 single done pulse", done, 1'b0);
    end
    chk("R12 load while busy ignored", sp, 16'h005E);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd7;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 op7 ignored busy", busy, 1'b0);
      chk("R9 op7 ignored done", done, 1'b0);
      @(negedge clk);
    end
    chk("R9 op7 ignored sp", sp, 16'h005E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 3'd7; condTaken = 1'b0;
    cmdWord = '0; retAddr = '0; vecOpcode = '0; pswSel = 1'b0;
    accIn = '0; flagsIn = '0; spWrEn = 1'b0; spWrVal = '0;
    tbWe = 1'b0; tbAddr = '0; tbData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPushPop();
    testNested();
    testCond();
    testPsw();
    testWrap();
    testBusyIgnore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule